// File: doc/BRIEF.md
# Interrupt Request Capture Stage

This block turns a vector of raw, active-high interrupt request lines into sticky pending bits and reports the single interrupt that should be serviced next. Each line is set up by its own mode bit to fire either while it is held high (level) or only on a low-to-high change (edge). A one-cycle copy of the raw inputs, kept apart from the pending state, supplies the "previous value" for edge detection. Clearing a pending bit therefore never looks like a fresh edge.

Software or a control block drives a per-line enable mask and a per-line mode mask. When it has handled the reported interrupt, it pulses a single end-of-interrupt input. That pulse clears only the interrupt being reported at that moment. The reported interrupt is the lowest-numbered line that is both pending and enabled. It is derived from the registered pending state on every cycle.

Top module: `irq_capture`

## Requirements
- R1: While `rst` is high at a clock edge, every pending bit and the input shadow are cleared. After that edge `pending` reads 0, `irq_valid` reads 0 and `irq_id` reads 0.
- R2: A line whose mode bit is 1 (level) and whose enable bit is 1 sets its pending bit at every clock edge where its raw input is 1. The bit is visible on `pending` right after that edge.
- R3: A line whose mode bit is 0 (edge) and whose enable bit is 1 sets its pending bit only at an edge where its raw input is 1 and was 0 at the previous clock edge. An input held high does not set the bit again. After reset, the previous value counts as 0.
- R4: When `eoi` clears the pending bit of an edge-mode line whose raw input stays high, the bit stays clear until the input has gone low and high again.
- R5: A line whose enable bit is 0 never has its pending bit set, whatever its raw input does.
- R6: Clearing a line's enable bit keeps its existing pending bit on `pending`, but the line is left out of `irq_valid` and `irq_id`.
- R7: `irq_valid` is 1 exactly when some line is both pending and enabled. `irq_id` then gives the lowest such line number (bit 0 has highest priority). With no such line, `irq_id` is 0.
- R8: A clock edge with `eoi` high clears only the pending bit of the line reported on `irq_id`. It has no effect when `irq_valid` is 0.
- R9: If the line reported on `irq_id` is cleared by `eoi` and also triggers at the same edge, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_raw | input | N_LINES | Raw active-high interrupt request lines |
| trig_mode | input | N_LINES | Per-line mode: 1 = level, 0 = rising edge |
| line_en | input | N_LINES | Per-line enable |
| eoi | input | 1 | End-of-interrupt pulse, clears the reported line |
| pending | output | N_LINES | Sticky pending bits |
| irq_valid | output | 1 | Some enabled line is pending |
| irq_id | output | ID_W | Lowest enabled pending line number |

## Verification
Random request vectors against random mode and enable masks separate level firing from edge firing. They also show whether the shadow, rather than the pending state, supplies the previous value. Directed sequences cover the remaining cases:
- An edge line is held high across an end-of-interrupt, to expose any refiring after a clear.
- A level line is held high across the same pulse, to show that a set wins over the clear.
- Several lines are pending with mixed enables, to check the priority order and masking.
- An end-of-interrupt is pulsed with nothing reported, to confirm that it changes nothing.

// File: rtl/intcap_pkg.sv
package intcap_pkg;

    localparam int unsigned DEF_LINES = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_kind_e;

    function automatic int unsigned id_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/intcap_shadow.sv
module intcap_shadow #(
    parameter int unsigned N_LINES = intcap_pkg::DEF_LINES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] raw_in,
    output logic [N_LINES-1:0] prev_raw
);

    logic [N_LINES-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) shadow_q <= '0;
        else     shadow_q <= raw_in;
    end

    assign prev_raw = shadow_q;

    // R3
    shadow_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (prev_raw == $past(raw_in)));

endmodule

// File: rtl/intcap_qualify.sv
module intcap_qualify #(
    parameter int unsigned N_LINES = intcap_pkg::DEF_LINES
) (
    input  logic [N_LINES-1:0] raw_in,
    input  logic [N_LINES-1:0] prev_raw,
    input  logic [N_LINES-1:0] mode,
    input  logic [N_LINES-1:0] enable,
    output logic [N_LINES-1:0] fire
);
    import intcap_pkg::*;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic armed;
        always_comb begin
            armed = (trig_kind_e'(mode[g]) == TRIG_LEVEL) || !prev_raw[g];
            fire[g] = raw_in[g] && armed && enable[g];
        end
    end

endmodule

// File: rtl/intcap_pending.sv
module intcap_pending #(
    parameter int unsigned N_LINES = intcap_pkg::DEF_LINES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] fire,
    input  logic [N_LINES-1:0] clear,
    input  logic [N_LINES-1:0] raw_in,
    input  logic [N_LINES-1:0] prev_raw,
    input  logic [N_LINES-1:0] mode,
    input  logic [N_LINES-1:0] enable,
    output logic [N_LINES-1:0] pend
);

    logic [N_LINES-1:0] pend_q;
    logic [N_LINES-1:0] pend_d;

    always_comb pend_d = (pend_q & ~clear) | fire;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend = pend_q;

    // R5
    set_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_q & ~$past(pend_q) & ~$past(raw_in & enable)) == '0));

    // R3
    edge_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_q & ~$past(pend_q) & $past(prev_raw & ~mode)) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(fire) & ~pend_q) == '0));

    // R8
    one_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones($past(pend_q) & ~pend_q) <= 1));

    // R8
    no_clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(clear) == '0)) |-> (($past(pend_q) & ~pend_q) == '0));

endmodule

// File: rtl/intcap_select.sv
module intcap_select #(
    parameter int unsigned N_LINES = intcap_pkg::DEF_LINES,
    localparam int unsigned ID_W = intcap_pkg::id_width(N_LINES)
) (
    input  logic [N_LINES-1:0] cand,
    output logic               valid,
    output logic [ID_W-1:0]    id,
    output logic [N_LINES-1:0] grant
);

    always_comb begin
        valid = 1'b0;
        id    = '0;
        grant = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (!valid && cand[i]) begin
                valid    = 1'b1;
                id       = ID_W'(i);
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int unsigned N_LINES = intcap_pkg::DEF_LINES,
    localparam int unsigned ID_W = intcap_pkg::id_width(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] req_raw,
    input  logic [N_LINES-1:0] trig_mode,
    input  logic [N_LINES-1:0] line_en,
    input  logic               eoi,
    output logic [N_LINES-1:0] pending,
    output logic               irq_valid,
    output logic [ID_W-1:0]    irq_id
);

    logic [N_LINES-1:0] prev_raw;
    logic [N_LINES-1:0] fire;
    logic [N_LINES-1:0] clear;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] grant;
    logic [N_LINES-1:0] cand;

    intcap_shadow #(.N_LINES(N_LINES)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (req_raw),
        .prev_raw (prev_raw)
    );

    intcap_qualify #(.N_LINES(N_LINES)) u_qualify (
        .raw_in   (req_raw),
        .prev_raw (prev_raw),
        .mode     (trig_mode),
        .enable   (line_en),
        .fire     (fire)
    );

    intcap_pending #(.N_LINES(N_LINES)) u_pending (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .clear    (clear),
        .raw_in   (req_raw),
        .prev_raw (prev_raw),
        .mode     (trig_mode),
        .enable   (line_en),
        .pend     (pend)
    );

    assign cand = pend & line_en;

    intcap_select #(.N_LINES(N_LINES)) u_select (
        .cand  (cand),
        .valid (irq_valid),
        .id    (irq_id),
        .grant (grant)
    );

    assign clear   = (eoi && irq_valid) ? grant : '0;
    assign pending = pend;

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R6
    sel_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (line_en[irq_id] && pending[irq_id]));

    // R7
    sel_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ((pending & line_en & ((N_LINES'(1) << irq_id) - N_LINES'(1))) == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (pending == '0));

endmodule

// File: tb/irq_capture_test.sv
module irq_capture_test;
    localparam int N = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] req_raw = '0;
    logic [N-1:0] trig_mode = '0;
    logic [N-1:0] line_en = '0;
    logic eoi = 1'b0;
    logic [N-1:0] pending;
    logic irq_valid;
    logic [IW-1:0] irq_id;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] m_pend = '0;
    logic [N-1:0] m_shadow = '0;

    irq_capture #(.N_LINES(N)) uut (
        .clk(clk), .rst(rst), .req_raw(req_raw), .trig_mode(trig_mode),
        .line_en(line_en), .eoi(eoi), .pending(pending),
        .irq_valid(irq_valid), .irq_id(irq_id)
    );

    always #2 clk = ~clk;

    function automatic logic exp_valid(input logic [N-1:0] p, input logic [N-1:0] e);
        return |(p & e);
    endfunction

    function automatic logic [IW-1:0] exp_id(input logic [N-1:0] p, input logic [N-1:0] e);
        for (int i = N - 1; i >= 0; i--) begin
            if (p[i] && e[i]) exp_id = IW'(i);
        end
        if ((p & e) == '0) exp_id = '0;
    endfunction

    function automatic logic [N-1:0] exp_fire(input logic [N-1:0] r, input logic [N-1:0] s,
                                              input logic [N-1:0] m, input logic [N-1:0] e);
        return r & (~s | m) & e;
    endfunction

    task automatic check_all(input string tag);
        checks++;
        if (pending !== m_pend) begin
            errors++;
            $display("FAIL %s pending actual %b expected %b", tag, pending, m_pend);
        end
        checks++;
        if (irq_valid !== exp_valid(m_pend, line_en)) begin
            errors++;
            $display("FAIL %s irq_valid actual %b expected %b", tag, irq_valid, exp_valid(m_pend, line_en));
        end
        checks++;
        if (irq_id !== exp_id(m_pend, line_en)) begin
            errors++;
            $display("FAIL %s irq_id actual %0d expected %0d", tag, irq_id, exp_id(m_pend, line_en));
        end
    endtask

    // Drive one cycle of inputs, update the model at the edge, check after it.
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] m, input logic [N-1:0] e,
                        input logic x, input string tag);
        logic [N-1:0] clr;
        @(negedge clk);
        req_raw = r; trig_mode = m; line_en = e; eoi = x;
        clr = '0;
        if (x && exp_valid(m_pend, e)) clr[exp_id(m_pend, e)] = 1'b1;
        @(posedge clk);
        if (rst) begin
            m_pend = '0; m_shadow = '0;
        end else begin
            m_pend = (m_pend & ~clr) | exp_fire(r, m_shadow, m, e);
            m_shadow = r;
        end
        #1;
        check_all(tag);
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        // R1 reset state, with raw requests present
        step(8'hFF, 8'hFF, 8'hFF, 1'b0, "R1");
        step(8'hFF, 8'hFF, 8'hFF, 1'b1, "R1");
        rst = 1'b0;
        step(8'h00, 8'h00, 8'hFF, 1'b0, "R1");

        // R2 level line fires and stays; R9 set wins over clear
        step(8'h04, 8'h04, 8'hFF, 1'b0, "R2");
        step(8'h04, 8'h04, 8'hFF, 1'b1, "R9");
        step(8'h04, 8'h04, 8'hFF, 1'b1, "R9");
        step(8'h00, 8'h04, 8'hFF, 1'b1, "R8");

        // R3 edge line: rise sets, held high does not refire; R4 after clear
        step(8'h02, 8'h00, 8'hFF, 1'b0, "R3");
        step(8'h02, 8'h00, 8'hFF, 1'b1, "R4");
        step(8'h02, 8'h00, 8'hFF, 1'b0, "R4");
        step(8'h02, 8'h00, 8'hFF, 1'b0, "R3");
        step(8'h00, 8'h00, 8'hFF, 1'b0, "R3");
        step(8'h02, 8'h00, 8'hFF, 1'b0, "R3");
        step(8'h00, 8'h00, 8'hFF, 1'b1, "R8");

        // R8 eoi with nothing reported
        step(8'h00, 8'h00, 8'hFF, 1'b1, "R8");

        // R5 disabled line ignored
        step(8'h80, 8'h80, 8'h7F, 1'b0, "R5");
        step(8'h80, 8'h00, 8'h7F, 1'b0, "R5");

        // R7 priority, R6 masking of an existing pending bit
        step(8'h29, 8'h00, 8'hFF, 1'b0, "R7");
        step(8'h00, 8'h00, 8'hFE, 1'b0, "R6");
        step(8'h00, 8'h00, 8'hFE, 1'b1, "R6");
        step(8'h00, 8'h00, 8'hF6, 1'b1, "R6");
        step(8'h00, 8'h00, 8'hF6, 1'b1, "R8");
        step(8'h00, 8'h00, 8'hFF, 1'b1, "R7");
        step(8'h00, 8'h00, 8'hFF, 1'b1, "R8");

        // Random phase
        begin
            logic [N-1:0] m, e;
            m = N'($urandom);
            e = N'($urandom);
            for (int i = 0; i < 3000; i++) begin
                if (($urandom % 16) == 0) m = N'($urandom);
                if (($urandom % 16) == 0) e = N'($urandom) | N'($urandom);
                if (($urandom % 200) == 0) begin
                    rst = 1'b1;
                    step(N'($urandom), m, e, 1'b0, "R1");
                    rst = 1'b0;
                end else begin
                    step(N'($urandom) & N'($urandom), m, e, (($urandom % 3) == 0), "R7");
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule